// File: doc/BRIEF.md
# DDR Write Burst Capture

This block sits on the memory side of a double-data-rate SDRAM write path. A write command, sampled on the rising edge of the memory clock, names a bank, a starting column, a burst length and whether the row closes once the burst is done. Data arrives on both edges of a source-synchronous strobe. The first rising strobe edge after the command carries the first beat, and each following strobe edge carries the next beat. The block groups the beats into pairs, works out the column of each beat, and hands every pair, with its byte-lane mask bits, to a storage array. A mask bit that is set means the storage array does not write that beat.

A command becomes pending on the falling clock edge that follows it. The first rising strobe edge after that point takes the command. This holds for any strobe delay between 0.75 and 1.25 clock periods. A new write may follow the previous one on any clock edge. If it arrives exactly one burst later, the bursts join with no gap. If it arrives x cycles after the previous write and x is less than half that burst's length, the old burst keeps x pairs and the new burst takes over at the next rising strobe edge. When a burst has run out and no write is pending, strobe activity is ignored.

Top module: `ddr_wr_capture`

## Requirements
- R1: While reset is asserted and directly after it, `pair_stb`, `pair_ap_done` and all pair data, mask, bank and column outputs are zero.
- R2: The beat on the first rising strobe edge after a write command becomes `pair_data0`/`pair_mask0`, and the beat on the next falling edge becomes `pair_data1`/`pair_mask1`. Both are delivered with the command's bank.
- R3: Capture gives the same result with a command-to-first-rising-strobe delay of 0.75, 1.0 or 1.25 clock periods.
- R4: `bl_sel` selects the burst length: 0 gives 2 beats, 1 gives 4 beats, and 2 or 3 give 8 beats. A burst that is not cut short delivers exactly length/2 pairs.
- R5: Beat j of a burst of length L that starts at column c goes to column (c - c mod L) + ((c mod L + j) mod L). `pair_col0` holds the even beat's column and `pair_col1` the odd beat's column.
- R6: A write issued L/2 cycles after a write of length L continues the data stream with no gap. Its first pair follows the old burst's last pair directly.
- R7: A write issued x cycles after the previous one, with 0 < x < L/2, keeps exactly x pairs of the old burst. The following strobe pair belongs to the new write.
- R8: A strobe pulse that arrives when no burst is running and no write is pending delivers nothing. `pair_stb` and all pair outputs keep their values.
- R9: The storage array writes a beat only if its mask bit is low. A masked beat leaves the stored word unchanged.
- R10: `pair_ap_done` is 1 on the last pair of a burst that completed with auto-precharge set, and 0 on all other pairs. This includes the last kept pair of a burst that was cut short.
- R11: `pair_stb` toggles once for each delivered pair. The other pair outputs change only when it toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cmd | input | 1 | Write command strobe |
| wr_col | input | COLW | Starting column |
| wr_bank | input | BANKW | Bank address |
| wr_ap | input | 1 | Close the row once the burst completes |
| bl_sel | input | 2 | Burst length code (0:2, 1:4, 2/3:8) |
| dqs | input | 1 | Data strobe; both edges carry data |
| dq | input | DW | Write data |
| dm | input | 1 | Write mask for the current beat |
| pair_stb | output | 1 | Toggles once per delivered pair |
| pair_bank | output | BANKW | Bank of the pair |
| pair_col0 | output | COLW | Column of the even beat |
| pair_col1 | output | COLW | Column of the odd beat |
| pair_data0 | output | DW | Even beat data |
| pair_data1 | output | DW | Odd beat data |
| pair_mask0 | output | 1 | Even beat mask |
| pair_mask1 | output | 1 | Odd beat mask |
| pair_ap_done | output | 1 | Last pair of a completed auto-precharge burst |

## Verification
A wrong pair index or a wrong burst length shows up at the falling strobe edge of the pair where it occurs. It appears as a wrong column or as a `pair_stb` toggle that is extra or missing. A pending command taken by the wrong strobe edge moves every later pair of the stream by one slot, so the mismatch appears within one strobe period. A mask or truncation error can hide in the pair fields, but it shows up as a changed word when the bench's storage image is compared with the image built from the model.

// File: rtl/ddr_wr_capture.sv
module ddr_wr_capture #(
  parameter int DW    = 8,
  parameter int COLW  = 6,
  parameter int BANKW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic [COLW-1:0]  wr_col,
  input  logic [BANKW-1:0] wr_bank,
  input  logic             wr_ap,
  input  logic [1:0]       bl_sel,
  input  logic             dqs,
  input  logic [DW-1:0]    dq,
  input  logic             dm,
  output logic             pair_stb,
  output logic [BANKW-1:0] pair_bank,
  output logic [COLW-1:0]  pair_col0,
  output logic [COLW-1:0]  pair_col1,
  output logic [DW-1:0]    pair_data0,
  output logic [DW-1:0]    pair_data1,
  output logic             pair_mask0,
  output logic             pair_mask1,
  output logic             pair_ap_done
);
  localparam int CW = 3 + COLW + BANKW;

  logic [CW-1:0]    stage_cmd, arm_cmd;
  logic             stage_tog, arm_tog, take_tog;
  logic             act, cur_ap;
  logic [1:0]       cur_last, idx;
  logic [COLW-1:0]  cur_col;
  logic [BANKW-1:0] cur_bank;
  logic [DW-1:0]    d_even;
  logic             m_even;

  wire [1:0]       arm_bl   = arm_cmd[1:0];
  wire             arm_ap   = arm_cmd[2];
  wire [COLW-1:0]  arm_col  = arm_cmd[3 +: COLW];
  wire [BANKW-1:0] arm_bank = arm_cmd[3+COLW +: BANKW];
  wire             fresh    = arm_tog ^ take_tog;
  wire [1:0]       arm_last = (arm_bl == 2'd0) ? 2'd0 :
                              (arm_bl == 2'd1) ? 2'd1 : 2'd3;

  wire [COLW-1:0] wrap_m = COLW'({cur_last, 1'b1});
  wire [COLW-1:0] step0  = cur_col + COLW'({idx, 1'b0});
  wire [COLW-1:0] step1  = step0 + COLW'(1);
  wire [COLW-1:0] col0   = (cur_col & ~wrap_m) | (step0 & wrap_m);
  wire [COLW-1:0] col1   = (cur_col & ~wrap_m) | (step1 & wrap_m);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stage_cmd <= '0;
      stage_tog <= 1'b0;
    end else if (wr_cmd) begin
      stage_cmd <= {wr_bank, wr_col, wr_ap, bl_sel};
      stage_tog <= ~stage_tog;
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      arm_cmd <= '0;
      arm_tog <= 1'b0;
    end else if (stage_tog != arm_tog) begin
      arm_cmd <= stage_cmd;
      arm_tog <= stage_tog;
    end

  always_ff @(posedge dqs or negedge rst_n)
    if (!rst_n) begin
      take_tog <= 1'b0;
      act      <= 1'b0;
      cur_ap   <= 1'b0;
      cur_last <= '0;
      idx      <= '0;
      cur_col  <= '0;
      cur_bank <= '0;
      d_even   <= '0;
      m_even   <= 1'b0;
    end else begin
      d_even <= dq;
      m_even <= dm;
      if (fresh) begin
        take_tog <= arm_tog;
        act      <= 1'b1;
        idx      <= '0;
        cur_ap   <= arm_ap;
        cur_last <= arm_last;
        cur_col  <= arm_col;
        cur_bank <= arm_bank;
      end else if (act && idx != cur_last) begin
        idx <= idx + 2'd1;
      end else begin
        act <= 1'b0;
      end
    end

  always_ff @(negedge dqs or negedge rst_n)
    if (!rst_n) begin
      pair_stb     <= 1'b0;
      pair_bank    <= '0;
      pair_col0    <= '0;
      pair_col1    <= '0;
      pair_data0   <= '0;
      pair_data1   <= '0;
      pair_mask0   <= 1'b0;
      pair_mask1   <= 1'b0;
      pair_ap_done <= 1'b0;
    end else if (act) begin
      pair_stb     <= ~pair_stb;
      pair_bank    <= cur_bank;
      pair_col0    <= col0;
      pair_col1    <= col1;
      pair_data0   <= d_even;
      pair_data1   <= dq;
      pair_mask0   <= m_even;
      pair_mask1   <= dm;
      pair_ap_done <= cur_ap && (idx == cur_last);
    end
endmodule

// File: rtl/ddr_wr_capture_chk.sv
module ddr_wr_capture_chk #(
  parameter int DW    = 8,
  parameter int COLW  = 6,
  parameter int BANKW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_cmd,
  input logic             pair_stb,
  input logic [BANKW-1:0] pair_bank,
  input logic [COLW-1:0]  pair_col0,
  input logic [COLW-1:0]  pair_col1,
  input logic [DW-1:0]    pair_data0,
  input logic [DW-1:0]    pair_data1,
  input logic             pair_mask0,
  input logic             pair_mask1,
  input logic             pair_ap_done
);
  logic seen_cmd;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_cmd <= 1'b0;
    else if (wr_cmd) seen_cmd <= 1'b1;

  a_r11_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pair_stb) |-> ($stable(pair_data0) && $stable(pair_data1) &&
                           $stable(pair_bank) && $stable(pair_col0) && $stable(pair_col1)));

  a_r11_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pair_stb) |-> ($stable(pair_mask0) && $stable(pair_mask1) && $stable(pair_ap_done)));

  a_r5_col_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pair_stb) |-> (pair_col1[0] != pair_col0[0] &&
                            pair_col1[COLW-1:3] == pair_col0[COLW-1:3]));

  a_r8_no_pair_before_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pair_stb) |-> seen_cmd);
endmodule

bind ddr_wr_capture ddr_wr_capture_chk #(.DW(DW), .COLW(COLW), .BANKW(BANKW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .pair_stb(pair_stb),
  .pair_bank(pair_bank), .pair_col0(pair_col0), .pair_col1(pair_col1),
  .pair_data0(pair_data0), .pair_data1(pair_data1), .pair_mask0(pair_mask0),
  .pair_mask1(pair_mask1), .pair_ap_done(pair_ap_done)
);

// File: tb/ddr_wr_capture_test.sv
`timescale 1ns/1ps
module ddr_wr_capture_test;
  localparam int DW = 8, COLW = 6, BANKW = 2;

  logic clk = 0, rst_n = 0, wr_cmd = 0, wr_ap = 0, dqs = 0, dm = 0;
  logic [COLW-1:0] wr_col = '0;
  logic [BANKW-1:0] wr_bank = '0;
  logic [1:0] bl_sel = '0;
  logic [DW-1:0] dq = '0;
  logic pair_stb, pair_mask0, pair_mask1, pair_ap_done;
  logic [BANKW-1:0] pair_bank;
  logic [COLW-1:0] pair_col0, pair_col1;
  logic [DW-1:0] pair_data0, pair_data1;

  ddr_wr_capture #(.DW(DW), .COLW(COLW), .BANKW(BANKW)) uut (.*);

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic kind;
    logic [BANKW-1:0] bank;
    logic [COLW-1:0] c0, c1;
    logic [DW-1:0] d0, d1;
    logic m0, m1, ap;
  } exp_t;

  exp_t  q_exp[$];
  string q_tag[$];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] mem_ref [256];
  logic [DW-1:0] mem_dut [256];

  bit cmd_v[16], strobe_on[16], cmd_ap[16];
  int cmd_col[16], cmd_bank[16], cmd_bl[16];

  bit m_act = 0, m_ap = 0;
  int m_idx = 0, m_len = 2, m_col = 0, m_bank = 0;

  function automatic int col_of(int base, int len, int j);
    return (base - base % len) + ((base % len + j) % len);
  endfunction

  task automatic check(bit ok, string tag, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  task automatic clear_plan();
    for (int i = 0; i < 16; i++) begin
      cmd_v[i] = 0; strobe_on[i] = 0; cmd_ap[i] = 0;
      cmd_col[i] = 0; cmd_bank[i] = 0; cmd_bl[i] = 0;
    end
  endtask

  task automatic plan(int k, int col, int bank, int bls, bit ap);
    cmd_v[k] = 1; strobe_on[k] = 1;
    cmd_col[k] = col; cmd_bank[k] = bank; cmd_bl[k] = bls; cmd_ap[k] = ap;
  endtask

  task automatic pulse(realtime d, logic [DW-1:0] e, logic [DW-1:0] o, logic me, logic mo);
    #(4.0 + d - 1.0);
    dq = e; dm = me;
    #1.0 dqs = 1;
    #1.25 dq = o; dm = mo;
    #1.25 dqs = 0;
  endtask

  task automatic model_slot(int k, int seq, string tag, output exp_t x,
                            input logic [DW-1:0] e, input logic [DW-1:0] o,
                            input logic me, input logic mo);
    x = '0;
    if (cmd_v[k]) begin
      m_act = 1; m_idx = 0; m_col = cmd_col[k]; m_bank = cmd_bank[k]; m_ap = cmd_ap[k];
      m_len = (cmd_bl[k] == 0) ? 2 : (cmd_bl[k] == 1) ? 4 : 8;
    end else if (m_act && (m_idx + 1) * 2 < m_len) m_idx++;
    else m_act = 0;
    if (m_act) begin
      x.kind = 1;
      x.bank = BANKW'(m_bank);
      x.c0 = COLW'(col_of(m_col, m_len, 2 * m_idx));
      x.c1 = COLW'(col_of(m_col, m_len, 2 * m_idx + 1));
      x.d0 = e; x.d1 = o; x.m0 = me; x.m1 = mo;
      x.ap = m_ap && ((m_idx + 1) * 2 == m_len);
      if (!me) mem_ref[m_bank * 64 + int'(x.c0)] = e;
      if (!mo) mem_ref[m_bank * 64 + int'(x.c1)] = o;
    end
  endtask

  int seq = 0;
  task automatic run(string tag, realtime d, int ncyc);
    exp_t x;
    for (int k = 0; k < ncyc; k++) begin
      @(posedge clk); #1;
      wr_cmd = cmd_v[k];
      wr_col = COLW'(cmd_col[k]); wr_bank = BANKW'(cmd_bank[k]);
      wr_ap = cmd_ap[k]; bl_sel = 2'(cmd_bl[k]);
      if (strobe_on[k]) begin
        automatic logic [DW-1:0] e = DW'(seq * 7 + 1);
        automatic logic [DW-1:0] o = DW'(seq * 7 + 4);
        automatic logic me = (seq % 3 == 0);
        automatic logic mo = (seq % 4 == 1);
        seq++;
        model_slot(k, seq, tag, x, e, o, me, mo);
        q_exp.push_back(x);
        q_tag.push_back(x.kind ? tag : "R8");
        fork pulse(d, e, o, me, mo); join_none
      end
    end
    @(posedge clk); #1 wr_cmd = 0;
    repeat (5) @(posedge clk);
    #1;
    check(q_exp.size() == 0, "R11", $sformatf("%s: %0d expected pairs never seen", tag, q_exp.size()));
    begin
      int bad = 0;
      for (int a = 0; a < 256; a++) if (mem_ref[a] !== mem_dut[a]) bad++;
      check(bad == 0, "R9", $sformatf("%s: storage words differ got %0d exp 0", tag, bad));
    end
  endtask

  logic last_stb = 0;
  initial begin
    forever begin
      @(negedge dqs);
      #0.3;
      if (rst_n) begin
        if (q_exp.size() == 0) begin
          check(pair_stb == last_stb, "R8", "unexpected pair with no strobe plan");
        end else begin
          automatic exp_t x = q_exp.pop_front();
          automatic string t = q_tag.pop_front();
          if (x.kind) begin
            automatic exp_t g = {1'b1, pair_bank, pair_col0, pair_col1, pair_data0,
                                 pair_data1, pair_mask0, pair_mask1, pair_ap_done};
            check(pair_stb != last_stb, t, "pair_stb did not toggle got 0 exp 1");
            check(g == x, t, $sformatf("pair got %h exp %h", g, x));
            if (pair_stb != last_stb) begin
              if (!pair_mask0) mem_dut[int'(pair_bank) * 64 + int'(pair_col0)] = pair_data0;
              if (!pair_mask1) mem_dut[int'(pair_bank) * 64 + int'(pair_col1)] = pair_data1;
            end
          end else begin
            check(pair_stb == last_stb, "R8", $sformatf("ignored pulse toggled stb got %b exp %b", pair_stb, last_stb));
          end
        end
        last_stb = pair_stb;
      end
    end
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) begin mem_ref[a] = '0; mem_dut[a] = '0; end
    repeat (4) @(posedge clk);
    #1;
    check(pair_stb == 0 && pair_ap_done == 0 && pair_data0 == 0 && pair_data1 == 0 &&
          pair_col0 == 0 && pair_bank == 0 && pair_mask0 == 0, "R1",
          $sformatf("reset outputs got stb=%b d0=%h exp 0", pair_stb, pair_data0));
    rst_n = 1;
    @(posedge clk); #1;
    check(pair_stb == 0 && pair_ap_done == 0, "R1", "outputs moved after reset release");

    clear_plan(); plan(0, 5, 1, 1, 0); strobe_on[1] = 1; strobe_on[2] = 1; strobe_on[3] = 1;
    run("R2", 3.75, 5);

    clear_plan(); plan(0, 3, 2, 2, 1); for (int i = 1; i < 4; i++) strobe_on[i] = 1;
    run("R10", 6.25, 5);

    clear_plan(); plan(0, 9, 3, 0, 1); plan(1, 12, 0, 0, 0); plan(2, 31, 1, 0, 1); strobe_on[3] = 1;
    run("R6", 5.0, 5);

    clear_plan(); plan(0, 16, 2, 2, 1); strobe_on[1] = 1; plan(2, 22, 3, 1, 1); strobe_on[3] = 1;
    run("R7", 3.75, 5);

    clear_plan(); plan(0, 40, 0, 3, 0); for (int i = 1; i < 4; i++) strobe_on[i] = 1;
    plan(5, 1, 2, 1, 0); strobe_on[6] = 1;
    run("R4", 6.25, 8);

    clear_plan(); plan(0, 2, 1, 1, 1); strobe_on[1] = 1; strobe_on[2] = 1;
    plan(3, 7, 1, 1, 0); strobe_on[4] = 1;
    run("R5", 5.0, 6);

    for (int v = 0; v < 3; v++) begin
      clear_plan(); plan(0, 6 + v, 0, 1, 1); strobe_on[1] = 1;
      run("R3", 3.75 + 1.25 * v, 3);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule